// File: doc/BRIEF.md
# Raster Score and Timer Digit Renderer

This block draws four decimal digits onto a raster picture: the saucer score, the rocket score, and a two-digit timer made of a tens digit and a units digit. For every pixel it takes the current horizontal and vertical beam counts and the four 4-bit BCD counter values. It returns one digit-video bit, which is high when that pixel belongs to a lit stroke of a digit.

Each digit occupies a fixed 16x16 cell on the screen. An area decoder finds the cell that the beam is in and produces a 2-bit source select. A 4:1 multiplexer uses that select to pick one counter value, and a seven-segment decoder turns the value into segment enables. A pixel mask then lights a pixel only where an active segment covers the beam's position inside the cell.

The glyph is 8 pixels wide and 16 tall, with strokes 2 pixels thick. It sits in the left half of its cell, so the right half is always dark. The units cell starts 16 pixels right of the tens cell, which leaves an 8-pixel gap between the two timer digits. The result may be registered once before it leaves the block.

Top module: `raster_digit_renderer`

## Requirements
- R1: A cell covers h in [X, X+15] and v in [Y, Y+15] for its origin (X, Y). The origins are the parameters SAUCER_X/Y, ROCKET_X/Y and TIMER_X/Y for the tens digit. The units cell has origin (TIMER_X+16, TIMER_Y). Outside every cell, digit_video is 0.
- R2: Inside a cell the value drawn is the counter that belongs to that cell. The select codes are 0 = saucer, 1 = rocket, 2 = timer tens and 3 = timer units. Where cells overlap, the lowest code wins.
- R3: Segment bits are ordered {a,b,c,d,e,f,g}. Values 0-9 decode to the following patterns:
  - 0 = 1111110, 1 = 0110000, 2 = 1101101, 3 = 1111001, 4 = 0110011
  - 5 = 1011011, 6 = 0011111 (no top bar), 7 = 1110000, 8 = 1111111, 9 = 1110011 (no bottom bar)
- R4: Values 10-15 are not blanked as a group. They decode to the following patterns, so only 15 is fully dark:
  - 10 = 0001101, 11 = 0011001, 12 = 0100011
  - 13 = 1001011, 14 = 0001111, 15 = 0000000
- R5: Let the in-cell column be c and the row be r, both counted from 0 at the origin. Segment regions inside the cell are as follows, and a pixel is lit only inside the region of an active segment.
  - Horizontal bars span c 0-7: a covers r 0-1, g covers r 7-8, d covers r 14-15.
  - Vertical bars cover 2 columns: f is c 0-1 with r 0-7, e is c 0-1 with r 8-15, b is c 6-7 with r 0-7, c is c 6-7 with r 8-15.
- R6: Columns 8-15 of every cell are dark. This leaves an 8-pixel dark gap between the timer tens and units glyphs.
- R7: With OUT_REG=1 (the default), digit_video shows the inputs present at the previous rising clock edge. With OUT_REG=0 it is combinational.
- R8: While rst_n is low, digit_video is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cnt | input | HW (9) | Horizontal beam count |
| v_cnt | input | VW (8) | Vertical beam count |
| saucer_bcd | input | 4 | Saucer score digit |
| rocket_bcd | input | 4 | Rocket score digit |
| tens_bcd | input | 4 | Timer tens digit |
| units_bcd | input | 4 | Timer units digit |
| digit_video | output | 1 | Digit pixel, high = lit |

## Verification
The assertions assume that the four cells of the default placement do not overlap. They also assume that every cell lies wholly within the counter ranges, so that no cell wraps around a counter edge. The stimulus only ever uses the default origins, so every position the bench drives falls into at most one cell. The checker tracks its conditions with the same latency the OUT_REG setting gives, so it compares each digit_video bit against the beam position and counter value that produced it.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

    localparam int CELL_DIM = 16;
    localparam int GLYPH_W  = 8;
    localparam int STROKE   = 2;
    localparam int N_SRC    = 4;

    typedef enum logic [1:0] {
        SRC_SAUCER = 2'd0,
        SRC_ROCKET = 2'd1,
        SRC_TENS   = 2'd2,
        SRC_UNITS  = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
        logic e;
        logic f;
        logic g;
    } seg_t;

    // Segment patterns (R3, R4)
    function automatic seg_t bcd_to_seg(input logic [3:0] val);
        logic [6:0] p;
        unique case (val)
            4'd0:  p = 7'b1111110;
            4'd1:  p = 7'b0110000;
            4'd2:  p = 7'b1101101;
            4'd3:  p = 7'b1111001;
            4'd4:  p = 7'b0110011;
            4'd5:  p = 7'b1011011;
            4'd6:  p = 7'b0011111;
            4'd7:  p = 7'b1110000;
            4'd8:  p = 7'b1111111;
            4'd9:  p = 7'b1110011;
            4'd10: p = 7'b0001101;
            4'd11: p = 7'b0011001;
            4'd12: p = 7'b0100011;
            4'd13: p = 7'b1001011;
            4'd14: p = 7'b0001111;
            default: p = 7'b0000000;
        endcase
        return seg_t'(p);
    endfunction

endpackage

// File: rtl/rdr_cell_locator.sv
module rdr_cell_locator
    import rdr_pkg::*;
#(
    parameter int HW = 9,
    parameter int VW = 8,
    parameter logic [rdr_pkg::N_SRC*HW-1:0] ORG_X = '0,
    parameter logic [rdr_pkg::N_SRC*VW-1:0] ORG_Y = '0
) (
    input  logic [HW-1:0] h_cnt,
    input  logic [VW-1:0] v_cnt,
    output logic          hit,
    output src_sel_e      sel,
    output logic [3:0]    col,
    output logic [3:0]    row
);

    logic [N_SRC-1:0] in_cell;
    logic [3:0]       col_i [N_SRC];
    logic [3:0]       row_i [N_SRC];

    // R1: one offset comparator per cell
    for (genvar i = 0; i < N_SRC; i++) begin : g_cell
        logic [HW-1:0] dx;
        logic [VW-1:0] dy;
        assign dx = h_cnt - ORG_X[i*HW +: HW];
        assign dy = v_cnt - ORG_Y[i*VW +: VW];
        assign in_cell[i] = (dx[HW-1:4] == '0) && (dy[VW-1:4] == '0);
        assign col_i[i] = dx[3:0];
        assign row_i[i] = dy[3:0];
    end

    // R2: lowest select code wins
    always_comb begin
        sel = SRC_UNITS;
        col = col_i[N_SRC-1];
        row = row_i[N_SRC-1];
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (in_cell[i]) begin
                sel = src_sel_e'(i);
                col = col_i[i];
                row = row_i[i];
            end
        end
    end

    assign hit = |in_cell;

endmodule

// File: rtl/rdr_value_mux.sv
module rdr_value_mux
    import rdr_pkg::*;
(
    input  src_sel_e   sel,
    input  logic [3:0] saucer_bcd,
    input  logic [3:0] rocket_bcd,
    input  logic [3:0] tens_bcd,
    input  logic [3:0] units_bcd,
    output logic [3:0] value
);

    always_comb begin
        unique case (sel)
            SRC_SAUCER: value = saucer_bcd;
            SRC_ROCKET: value = rocket_bcd;
            SRC_TENS:   value = tens_bcd;
            SRC_UNITS:  value = units_bcd;
            default:    value = units_bcd;
        endcase
    end

endmodule

// File: rtl/rdr_seg_mask.sv
module rdr_seg_mask
    import rdr_pkg::*;
(
    input  logic       hit,
    input  seg_t       seg,
    input  logic [3:0] col,
    input  logic [3:0] row,
    output logic       pixel
);

    localparam int HALF_ROWS = CELL_DIM / 2;
    localparam int RIGHT_COL = GLYPH_W - STROKE;
    localparam int MID_ROW   = HALF_ROWS - 1;
    localparam int LOW_ROW   = CELL_DIM - STROKE;

    logic in_glyph, left, right, upper, lower;
    logic bar_top, bar_mid, bar_bot;

    // R5, R6: stroke regions inside the cell
    always_comb begin
        in_glyph = 32'(col) < GLYPH_W;
        left     = 32'(col) < STROKE;
        right    = (32'(col) >= RIGHT_COL) && in_glyph;
        upper    = 32'(row) < HALF_ROWS;
        lower    = !upper;
        bar_top  = 32'(row) < STROKE;
        bar_mid  = (32'(row) >= MID_ROW) && (32'(row) < MID_ROW + STROKE);
        bar_bot  = 32'(row) >= LOW_ROW;
        pixel = hit && in_glyph && (
                    (seg.a && bar_top) ||
                    (seg.g && bar_mid) ||
                    (seg.d && bar_bot) ||
                    (seg.f && left  && upper) ||
                    (seg.e && left  && lower) ||
                    (seg.b && right && upper) ||
                    (seg.c && right && lower));
    end

endmodule

// File: rtl/raster_digit_renderer.sv
module raster_digit_renderer
    import rdr_pkg::*;
#(
    parameter int HW       = 9,
    parameter int VW       = 8,
    parameter int SAUCER_X = 32,
    parameter int SAUCER_Y = 16,
    parameter int ROCKET_X = 208,
    parameter int ROCKET_Y = 16,
    parameter int TIMER_X  = 112,
    parameter int TIMER_Y  = 16,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_cnt,
    input  logic [VW-1:0] v_cnt,
    input  logic [3:0]    saucer_bcd,
    input  logic [3:0]    rocket_bcd,
    input  logic [3:0]    tens_bcd,
    input  logic [3:0]    units_bcd,
    output logic          digit_video
);

    localparam int UNITS_X = TIMER_X + CELL_DIM;
    localparam logic [N_SRC*HW-1:0] ORG_X =
        {HW'(UNITS_X), HW'(TIMER_X), HW'(ROCKET_X), HW'(SAUCER_X)};
    localparam logic [N_SRC*VW-1:0] ORG_Y =
        {VW'(TIMER_Y), VW'(TIMER_Y), VW'(ROCKET_Y), VW'(SAUCER_Y)};

    logic       hit;
    src_sel_e   sel;
    logic [3:0] col, row, value;
    seg_t       seg;
    logic       pixel;

    rdr_cell_locator #(
        .HW(HW), .VW(VW), .ORG_X(ORG_X), .ORG_Y(ORG_Y)
    ) u_locator (
        .h_cnt(h_cnt), .v_cnt(v_cnt),
        .hit(hit), .sel(sel), .col(col), .row(row)
    );

    rdr_value_mux u_mux (
        .sel(sel),
        .saucer_bcd(saucer_bcd), .rocket_bcd(rocket_bcd),
        .tens_bcd(tens_bcd), .units_bcd(units_bcd),
        .value(value)
    );

    assign seg = bcd_to_seg(value);

    rdr_seg_mask u_mask (
        .hit(hit), .seg(seg), .col(col), .row(row), .pixel(pixel)
    );

    // R7, R8: optional output register
    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) digit_video <= 1'b0;
            else        digit_video <= pixel;
        end
    end else begin : g_comb
        assign digit_video = pixel && rst_n;
    end

endmodule

// File: rtl/rdr_checker.sv
module rdr_checker #(
    parameter int HW       = 9,
    parameter int VW       = 8,
    parameter int SAUCER_X = 32,
    parameter int SAUCER_Y = 16,
    parameter int ROCKET_X = 208,
    parameter int ROCKET_Y = 16,
    parameter int TIMER_X  = 112,
    parameter int TIMER_Y  = 16,
    parameter bit OUT_REG  = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic [3:0]    saucer_bcd,
    input logic          digit_video
);

    localparam logic [15:0] TOP_BAR_LIT = 16'h23AD;

    function automatic bit inside_at(input int x0, input int y0,
                                     output int cx, output int ry);
        cx = int'(h_cnt) - x0;
        ry = int'(v_cnt) - y0;
        return (cx >= 0) && (cx < 16) && (ry >= 0) && (ry < 16);
    endfunction

    logic c_outside, c_right, c_top, top_exp;

    always_comb begin
        int cx0, ry0, cx1, ry1, cx2, ry2, cx3, ry3;
        bit i0, i1, i2, i3;
        i0 = inside_at(SAUCER_X, SAUCER_Y, cx0, ry0);
        i1 = inside_at(ROCKET_X, ROCKET_Y, cx1, ry1);
        i2 = inside_at(TIMER_X, TIMER_Y, cx2, ry2);
        i3 = inside_at(TIMER_X + 16, TIMER_Y, cx3, ry3);
        c_outside = !(i0 || i1 || i2 || i3);
        c_right = (i0 && cx0 >= 8) || (i1 && cx1 >= 8) ||
                  (i2 && cx2 >= 8) || (i3 && cx3 >= 8);
        c_top   = i0 && (cx0 < 8) && (ry0 < 2);
        top_exp = TOP_BAR_LIT[saucer_bcd];
    end

    logic d_outside, d_right, d_top, d_exp;

    if (OUT_REG) begin : g_lag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_outside <= 1'b0;
                d_right   <= 1'b0;
                d_top     <= 1'b0;
                d_exp     <= 1'b0;
            end else begin
                d_outside <= c_outside;
                d_right   <= c_right;
                d_top     <= c_top;
                d_exp     <= top_exp;
            end
        end
    end else begin : g_now
        assign d_outside = c_outside;
        assign d_right   = c_right;
        assign d_top     = c_top;
        assign d_exp     = top_exp;
    end

    // R1
    outside_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_outside |-> !digit_video);

    // R6
    right_half_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_right |-> !digit_video);

    // R5
    top_bar_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_top |-> (digit_video == d_exp));

    // R8
    reset_dark_chk: assert property (@(posedge clk)
        (!rst_n && !$isunknown(digit_video)) |-> !digit_video);

endmodule

bind raster_digit_renderer rdr_checker #(
    .HW(HW), .VW(VW),
    .SAUCER_X(SAUCER_X), .SAUCER_Y(SAUCER_Y),
    .ROCKET_X(ROCKET_X), .ROCKET_Y(ROCKET_Y),
    .TIMER_X(TIMER_X), .TIMER_Y(TIMER_Y),
    .OUT_REG(OUT_REG)
) u_rdr_checker (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .saucer_bcd(saucer_bcd), .digit_video(digit_video)
);

// File: tb/tb_raster_digit_renderer.sv
module tb_raster_digit_renderer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] h_cnt = '0;
    logic [7:0] v_cnt = '0;
    logic [3:0] saucer_bcd = '0, rocket_bcd = '0, tens_bcd = '0, units_bcd = '0;
    logic       digit_video;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    raster_digit_renderer dut (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .saucer_bcd(saucer_bcd), .rocket_bcd(rocket_bcd),
        .tens_bcd(tens_bcd), .units_bcd(units_bcd),
        .digit_video(digit_video)
    );

    // Cells: saucer h32 v16, rocket h208 v16, tens h112 v16, units h128 v16
    // {h, v, saucer, rocket, tens, units, expected}
    localparam int NV = 20;
    localparam logic [33:0] VEC [NV] = '{
        {9'd0,   8'd0,  4'd8,  4'd8, 4'd8, 4'd8,  1'b0},
        {9'd35,  8'd16, 4'd0,  4'd0, 4'd0, 4'd0,  1'b1},
        {9'd35,  8'd16, 4'd1,  4'd0, 4'd0, 4'd0,  1'b0},
        {9'd42,  8'd20, 4'd8,  4'd8, 4'd8, 4'd8,  1'b0},
        {9'd211, 8'd23, 4'd0,  4'd8, 4'd0, 4'd0,  1'b1},
        {9'd211, 8'd23, 4'd8,  4'd0, 4'd8, 4'd8,  1'b0},
        {9'd112, 8'd19, 4'd0,  4'd0, 4'd5, 4'd0,  1'b1},
        {9'd119, 8'd19, 4'd8,  4'd8, 4'd5, 4'd8,  1'b0},
        {9'd135, 8'd28, 4'd0,  4'd0, 4'd0, 4'd7,  1'b1},
        {9'd129, 8'd28, 4'd8,  4'd8, 4'd8, 4'd7,  1'b0},
        {9'd124, 8'd16, 4'd8,  4'd8, 4'd8, 4'd8,  1'b0},
        {9'd131, 8'd16, 4'd8,  4'd8, 4'd8, 4'd15, 1'b0},
        {9'd131, 8'd31, 4'd8,  4'd8, 4'd8, 4'd15, 1'b0},
        {9'd129, 8'd28, 4'd8,  4'd8, 4'd8, 4'd10, 1'b1},
        {9'd115, 8'd17, 4'd8,  4'd8, 4'd6, 4'd8,  1'b0},
        {9'd115, 8'd30, 4'd8,  4'd8, 4'd9, 4'd8,  1'b0},
        {9'd35,  8'd20, 4'd8,  4'd8, 4'd8, 4'd8,  1'b0},
        {9'd34,  8'd31, 4'd2,  4'd0, 4'd0, 4'd0,  1'b1},
        {9'd211, 8'd16, 4'd0,  4'd1, 4'd0, 4'd0,  1'b0},
        {9'd35,  8'd32, 4'd8,  4'd8, 4'd8, 4'd8,  1'b0}
    };
    string TAG [NV] = '{
        "R1 outside", "R3 zero top bar", "R3 one no top bar", "R6 right half",
        "R2 rocket g", "R2 rocket zero no g", "R5 f upper left", "R5 b absent",
        "R5 c lower right", "R5 e absent", "R6 timer gap", "R4 fifteen top",
        "R4 fifteen bottom", "R4 ten e", "R3 six no top", "R3 nine no bottom",
        "R5 interior dark", "R5 d bottom", "R2 rocket cell value", "R1 below cell"
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [33:0] v);
        {h_cnt, v_cnt, saucer_bcd, rocket_bcd, tens_bcd, units_bcd} = v[33:1];
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset holds output low while a lit pixel is presented
        drive(VEC[1]);
        repeat (3) @(posedge clk);
        #2 check("R8 reset dark", digit_video, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // Vector table, one cycle latency (R7)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) drive(VEC[i]);
            @(posedge clk);
            #2 check(TAG[i], digit_video, VEC[i][0]);
        end

        // R7: change is not visible before the next edge
        @(negedge clk) drive(VEC[0]);
        @(posedge clk);
        @(negedge clk) drive(VEC[1]);
        #1 check("R7 before edge", digit_video, 1'b0);
        @(posedge clk);
        #2 check("R7 after edge", digit_video, 1'b1);

        // R8: asynchronous reset clears a lit output
        #1 rst_n = 1'b0;
        #1 check("R8 async clear", digit_video, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule